// File: doc/BRIEF.md
# NAND Flash Boot Initialization Sequencer

This block runs once each time its reset is released and brings an attached 8-bit NAND flash into a state from which a processor can boot. On the first cycle after reset it captures three strap inputs. Then, unless told to skip it, it runs device discovery. Discovery reads the parameter page and checks its four-byte signature. If that signature is wrong, it falls back to a legacy ID read. Either path latches the manufacturer, device code and page size into parameter outputs. After discovery the block resets the device and, unless inhibited, loads block 0 page 0 so that the page can be read directly. It ends by raising a reset-complete flag.

The flash is driven through an abstract byte interface. In any cycle at most one operation is issued: a command byte, an address byte or a data read. The device's ready/busy line is watched after every command that starts an internal operation. A wait that outlasts a programmable limit sets an error flag and ends the sequence, so the block never hangs.

States, in order of use:
- `ST_SAMPLE`: capture the straps. Goes to `ST_RST_CMD` if skip-init is set, otherwise to `ST_PP_CMD`.
- `ST_PP_CMD` → `ST_PP_ADDR` → `ST_PP_WAIT`: issue the parameter-page read and wait for ready.
- `ST_PP_READ`: read the page. A signature mismatch after byte 3 goes to `ST_ID_CMD`. Reaching the last byte goes to `ST_RST_CMD`.
- `ST_ID_CMD` → `ST_ID_ADDR` → `ST_ID_READ`: after 4 bytes, go to `ST_RST_CMD`.
- `ST_RST_CMD` → `ST_RST_WAIT`: go to `ST_LD_CMD`, or to `ST_DONE` if the preload is inhibited.
- `ST_LD_CMD` → `ST_LD_ADDR` → `ST_LD_CONF` → `ST_LD_WAIT` → `ST_DONE`.
- Any wait state goes to `ST_DONE` on timeout.

Top module: `nand_boot_seq`

## Requirements
- R1: The three strap inputs are captured in the first clock cycle after reset release. Changes to them later have no effect until the next reset.
- R2: With skip-init set, no command 0xEC, no command 0x90 and no read is issued. The first operation is command 0xFF, `onfi_found` stays 0, and `par_page` holds DEF_PAGE (2048), or 512 if the small-page strap is set.
- R3: Discovery issues command 0xEC and then address 0x00. It waits for `io_rdy` high and then reads bytes. The signature is valid only when bytes 0..3 equal 0x4F, 0x4E, 0x46 and 0x49; a valid signature sets `onfi_found`.
- R4: With a valid signature the block reads bytes 0 through OFS_PAGE+1 (82 reads by default). `par_mfr` takes byte OFS_MFR (64). `par_page` takes byte OFS_PAGE (80) as its low byte and byte OFS_PAGE+1 as its high byte. `par_dev` stays 0.
- R5: On a signature mismatch the parameter read stops after byte 3. The block then issues command 0x90, address 0x00 and 4 reads. ID byte 0 goes to `par_mfr` and byte 1 to `par_dev`. `par_page` becomes 1024 shifted left by bits [1:0] of ID byte 3.
- R6: With the small-page strap set, `par_page` reads 512 at completion, whatever the device reported.
- R7: After discovery, or straight after sampling when skip-init is set, the block issues command 0xFF and waits for `io_rdy` high.
- R8: Unless the no-preload strap is set, the block then issues command 0x00, ADDR_CYCLES (5) address bytes of 0x00 and command 0x30, and waits for ready. With no-preload set, the sequence ends after the device reset.
- R9: `busy` is high from reset until completion. At completion `rst_done` rises and `busy` falls. Both hold until the next reset, and no further operation is issued.
- R10: If `io_rdy` stays low for TMO_CYCLES cycles in any wait, `err_timeout` is set, the sequence completes at once and no further operation is issued.
- R11: During reset `rst_done`, `err_timeout`, `onfi_found` and `io_valid` are 0 and `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_skip_init | input | 1 | Skip device discovery |
| strap_small_page | input | 1 | Treat the device as a 512-byte page part |
| strap_no_preload | input | 1 | Suppress the block 0 page 0 load |
| io_din | input | 8 | Read data byte, captured on the edge that ends a read cycle |
| io_rdy | input | 1 | Device ready (1) / busy (0) |
| io_valid | output | 1 | An operation is issued this cycle |
| io_kind | output | 2 | 0 command, 1 address, 2 read |
| io_dout | output | 8 | Command or address byte (0 during reads) |
| busy | output | 1 | Sequence in progress |
| rst_done | output | 1 | Reset-complete status flag |
| err_timeout | output | 1 | A ready/busy wait timed out |
| onfi_found | output | 1 | A valid parameter signature was seen |
| par_mfr | output | 8 | Manufacturer byte |
| par_dev | output | 8 | Device code byte (legacy path) |
| par_page | output | PAGE_W | Page size in bytes |

## Verification
The bench builds the block with TMO_CYCLES set to 64 and leaves all other parameters at their defaults. A timeout can then be provoked in tens of cycles rather than thousands, so the runs that hang the parameter-page wait and the reset wait both fit in a short run. The default offsets keep the full 82-byte parameter read. The default 5 address cycles let the preload ordering be compared byte for byte against an operation log. The device model uses a near-miss signature, with only byte 3 wrong, so the legacy fallback must come from a check of all four bytes.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

    typedef enum logic [1:0] {
        IO_CMD  = 2'd0,
        IO_ADDR = 2'd1,
        IO_READ = 2'd2
    } io_kind_e;

    typedef enum logic [3:0] {
        ST_SAMPLE,
        ST_PP_CMD,
        ST_PP_ADDR,
        ST_PP_WAIT,
        ST_PP_READ,
        ST_ID_CMD,
        ST_ID_ADDR,
        ST_ID_READ,
        ST_RST_CMD,
        ST_RST_WAIT,
        ST_LD_CMD,
        ST_LD_ADDR,
        ST_LD_CONF,
        ST_LD_WAIT,
        ST_DONE
    } state_e;

    typedef struct packed {
        logic skip_init;
        logic small_page;
        logic no_preload;
    } strap_t;

    localparam logic [7:0] OP_RESET   = 8'hFF;
    localparam logic [7:0] OP_PARAM   = 8'hEC;
    localparam logic [7:0] OP_READID  = 8'h90;
    localparam logic [7:0] OP_PAGE_A  = 8'h00;
    localparam logic [7:0] OP_PAGE_B  = 8'h30;
    localparam logic [7:0] ADDR_ZERO  = 8'h00;

    function automatic logic [7:0] sig_byte(input logic [1:0] pos);
        case (pos)
            2'd0:    sig_byte = 8'h4F;
            2'd1:    sig_byte = 8'h4E;
            2'd2:    sig_byte = 8'h46;
            default: sig_byte = 8'h49;
        endcase
    endfunction

endpackage

// File: rtl/nbs_wait_timer.sv
module nbs_wait_timer #(
    parameter int LIMIT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic rdy,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    assign expired = active && !rdy && (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!active || rdy || expired) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R10: the wait counter never runs past its limit
    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(LIMIT));

endmodule

// File: rtl/nbs_sig_check.sv
module nbs_sig_check
    import nbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       en,
    input  logic [1:0] pos,
    input  logic [7:0] din,
    output logic       sig_ok
);
    logic bad;
    logic hit;

    assign hit    = (din == sig_byte(pos));
    assign sig_ok = !bad && hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bad <= 1'b0;
        end else if (clear) begin
            bad <= 1'b0;
        end else if (en && !hit) begin
            bad <= 1'b1;
        end
    end

    // R3: once a signature byte has mismatched, the mismatch is remembered
    p_bad_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bad && !clear) |=> bad);

endmodule

// File: rtl/nbs_param_regs.sv
module nbs_param_regs #(
    parameter int PAGE_W   = 16,
    parameter int DEF_PAGE = 2048,
    parameter int SMALL_PG = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        din,
    input  logic              cap_mfr,
    input  logic              cap_dev,
    input  logic              cap_pg_lo,
    input  logic              cap_pg_hi,
    input  logic              cap_pg_code,
    input  logic              force_small,
    output logic [7:0]        mfr,
    output logic [7:0]        dev,
    output logic [PAGE_W-1:0] page
);
    localparam logic [PAGE_W-1:0] PG_BASE = PAGE_W'(1024);

    logic [PAGE_W-1:0] page_r;

    assign page = force_small ? PAGE_W'(SMALL_PG) : page_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mfr    <= '0;
            dev    <= '0;
            page_r <= PAGE_W'(DEF_PAGE);
        end else begin
            if (cap_mfr)     mfr <= din;
            if (cap_dev)     dev <= din;
            if (cap_pg_lo)   page_r[7:0]  <= din;
            if (cap_pg_hi)   page_r[15:8] <= din;
            if (cap_pg_code) page_r <= PG_BASE << din[1:0];
        end
    end

endmodule

// File: rtl/nand_boot_seq.sv
module nand_boot_seq
    import nbs_pkg::*;
#(
    parameter int TMO_CYCLES  = 4096,
    parameter int ADDR_CYCLES = 5,
    parameter int OFS_MFR     = 64,
    parameter int OFS_PAGE    = 80,
    parameter int DEF_PAGE    = 2048,
    parameter int PAGE_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_skip_init,
    input  logic              strap_small_page,
    input  logic              strap_no_preload,
    input  logic [7:0]        io_din,
    input  logic              io_rdy,
    output logic              io_valid,
    output logic [1:0]        io_kind,
    output logic [7:0]        io_dout,
    output logic              busy,
    output logic              rst_done,
    output logic              err_timeout,
    output logic              onfi_found,
    output logic [7:0]        par_mfr,
    output logic [7:0]        par_dev,
    output logic [PAGE_W-1:0] par_page
);
    localparam int PP_LEN = OFS_PAGE + 2;
    localparam int ID_LEN = 4;
    localparam int IW     = $clog2(PP_LEN + 1);

    state_e         st, st_nx;
    strap_t         strap_q, strap_now;
    logic [IW-1:0]  idx;
    logic           wait_act, tmo, sig_ok;
    logic           in_pp_read, in_id_read;

    assign strap_now  = (st == ST_SAMPLE)
                      ? '{skip_init: strap_skip_init, small_page: strap_small_page,
                          no_preload: strap_no_preload}
                      : strap_q;
    assign wait_act   = (st == ST_PP_WAIT) || (st == ST_RST_WAIT) || (st == ST_LD_WAIT);
    assign in_pp_read = (st == ST_PP_READ);
    assign in_id_read = (st == ST_ID_READ);
    assign busy       = (st != ST_DONE);

    nbs_wait_timer #(.LIMIT(TMO_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (wait_act),
        .rdy     (io_rdy),
        .expired (tmo)
    );

    nbs_sig_check u_sig (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (st == ST_SAMPLE),
        .en     (in_pp_read && (idx < IW'(ID_LEN))),
        .pos    (idx[1:0]),
        .din    (io_din),
        .sig_ok (sig_ok)
    );

    nbs_param_regs #(.PAGE_W(PAGE_W), .DEF_PAGE(DEF_PAGE)) u_par (
        .clk         (clk),
        .rst_n       (rst_n),
        .din         (io_din),
        .cap_mfr     ((in_pp_read && idx == IW'(OFS_MFR)) || (in_id_read && idx == IW'(0))),
        .cap_dev     (in_id_read && idx == IW'(1)),
        .cap_pg_lo   (in_pp_read && idx == IW'(OFS_PAGE)),
        .cap_pg_hi   (in_pp_read && idx == IW'(OFS_PAGE + 1)),
        .cap_pg_code (in_id_read && idx == IW'(3)),
        .force_small (strap_q.small_page && (st != ST_SAMPLE)),
        .mfr         (par_mfr),
        .dev         (par_dev),
        .page        (par_page)
    );

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_SAMPLE:   st_nx = strap_now.skip_init ? ST_RST_CMD : ST_PP_CMD;
            ST_PP_CMD:   st_nx = ST_PP_ADDR;
            ST_PP_ADDR:  st_nx = ST_PP_WAIT;
            ST_PP_WAIT:  if (tmo) st_nx = ST_DONE;
                         else if (io_rdy) st_nx = ST_PP_READ;
            ST_PP_READ:  if (idx == IW'(ID_LEN - 1) && !sig_ok) st_nx = ST_ID_CMD;
                         else if (idx == IW'(PP_LEN - 1)) st_nx = ST_RST_CMD;
            ST_ID_CMD:   st_nx = ST_ID_ADDR;
            ST_ID_ADDR:  st_nx = ST_ID_READ;
            ST_ID_READ:  if (idx == IW'(ID_LEN - 1)) st_nx = ST_RST_CMD;
            ST_RST_CMD:  st_nx = ST_RST_WAIT;
            ST_RST_WAIT: if (tmo) st_nx = ST_DONE;
                         else if (io_rdy) st_nx = strap_q.no_preload ? ST_DONE : ST_LD_CMD;
            ST_LD_CMD:   st_nx = ST_LD_ADDR;
            ST_LD_ADDR:  if (idx == IW'(ADDR_CYCLES - 1)) st_nx = ST_LD_CONF;
            ST_LD_CONF:  st_nx = ST_LD_WAIT;
            ST_LD_WAIT:  if (tmo || io_rdy) st_nx = ST_DONE;
            ST_DONE:     st_nx = ST_DONE;
            default:     st_nx = ST_DONE;
        endcase
    end

    // state register and sequence status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st          <= ST_SAMPLE;
            strap_q     <= '0;
            idx         <= '0;
            rst_done    <= 1'b0;
            err_timeout <= 1'b0;
            onfi_found  <= 1'b0;
        end else begin
            st <= st_nx;
            if (st == ST_SAMPLE) strap_q <= strap_now;
            if (st_nx != st) idx <= '0;
            else             idx <= idx + 1'b1;
            if (st_nx == ST_DONE) rst_done <= 1'b1;
            if (tmo) err_timeout <= 1'b1;
            if (in_pp_read && idx == IW'(ID_LEN - 1) && sig_ok) onfi_found <= 1'b1;
        end
    end

    // flash byte interface outputs
    always_comb begin
        io_valid = 1'b0;
        io_kind  = IO_CMD;
        io_dout  = 8'h00;
        unique case (st)
            ST_PP_CMD:   begin io_valid = 1'b1; io_dout = OP_PARAM;  end
            ST_ID_CMD:   begin io_valid = 1'b1; io_dout = OP_READID; end
            ST_RST_CMD:  begin io_valid = 1'b1; io_dout = OP_RESET;  end
            ST_LD_CMD:   begin io_valid = 1'b1; io_dout = OP_PAGE_A; end
            ST_LD_CONF:  begin io_valid = 1'b1; io_dout = OP_PAGE_B; end
            ST_PP_ADDR, ST_ID_ADDR, ST_LD_ADDR: begin
                io_valid = 1'b1; io_kind = IO_ADDR; io_dout = ADDR_ZERO;
            end
            ST_PP_READ, ST_ID_READ: begin
                io_valid = 1'b1; io_kind = IO_READ;
            end
            default: ;
        endcase
    end

    // R1: captured straps do not move after the sampling cycle
    p_strap_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_SAMPLE) |=> $stable(strap_q));

    // R2: skip-init issues no reads
    p_skip_no_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (strap_q.skip_init && st != ST_SAMPLE && io_valid) |-> (io_kind != IO_READ));

    // R3: reads only happen while the device is ready
    p_read_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && io_kind == IO_READ) |-> io_rdy);

    // R6: small-page strap overrides the reported page size
    p_small_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_done && strap_q.small_page) |-> (par_page == PAGE_W'(512)));

    // R9: completion is sticky and clears busy
    p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_done |=> (rst_done && !busy && !io_valid));

    // R10: a timeout ends all bus activity
    p_quiet_tmo_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |-> !io_valid);

endmodule

// File: tb/tb_nand_boot_seq.sv
`timescale 1ns/1ps
module tb_nand_boot_seq;
    localparam int TMO  = 64;
    localparam int BUSY = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic s_skip = 1'b0, s_small = 1'b0, s_nopl = 1'b0;
    logic [7:0] io_din;
    logic io_rdy;
    logic io_valid;
    logic [1:0] io_kind;
    logic [7:0] io_dout;
    logic busy, rst_done, err_timeout, onfi_found;
    logic [7:0] par_mfr, par_dev;
    logic [15:0] par_page;

    always #2 clk = ~clk;

    nand_boot_seq #(.TMO_CYCLES(TMO)) dut (
        .clk(clk), .rst_n(rst_n),
        .strap_skip_init(s_skip), .strap_small_page(s_small), .strap_no_preload(s_nopl),
        .io_din(io_din), .io_rdy(io_rdy),
        .io_valid(io_valid), .io_kind(io_kind), .io_dout(io_dout),
        .busy(busy), .rst_done(rst_done), .err_timeout(err_timeout), .onfi_found(onfi_found),
        .par_mfr(par_mfr), .par_dev(par_dev), .par_page(par_page)
    );

    // ---------------- device model ----------------
    logic       dev_onfi = 1'b1;
    logic       hang_en  = 1'b0;
    logic [7:0] hang_op  = 8'h00;
    logic [7:0] cur_cmd;
    logic [7:0] rd_ptr;
    logic       hanging;
    int         bcnt;

    function automatic logic [7:0] pp_byte(input logic [7:0] i, input logic good);
        case (i)
            8'd0:  pp_byte = 8'h4F;
            8'd1:  pp_byte = 8'h4E;
            8'd2:  pp_byte = 8'h46;
            8'd3:  pp_byte = good ? 8'h49 : 8'h00;
            8'd64: pp_byte = 8'h2C;
            8'd80: pp_byte = 8'h00;
            8'd81: pp_byte = 8'h20;
            default: pp_byte = 8'hA5;
        endcase
    endfunction

    function automatic logic [7:0] id_byte(input logic [7:0] i);
        case (i)
            8'd0: id_byte = 8'hAD;
            8'd1: id_byte = 8'hDC;
            8'd2: id_byte = 8'h10;
            default: id_byte = 8'h96;
        endcase
    endfunction

    always_comb begin
        if (cur_cmd == 8'hEC)      io_din = pp_byte(rd_ptr, dev_onfi);
        else if (cur_cmd == 8'h90) io_din = id_byte(rd_ptr);
        else                       io_din = 8'h00;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            cur_cmd <= 8'h00; rd_ptr <= 8'h00; io_rdy <= 1'b1; bcnt <= 0; hanging <= 1'b0;
        end else if (io_valid && io_kind == 2'd0) begin
            cur_cmd <= io_dout;
            rd_ptr  <= 8'h00;
            if (io_dout == 8'hFF || io_dout == 8'hEC || io_dout == 8'h30) begin
                io_rdy  <= 1'b0;
                bcnt    <= BUSY;
                hanging <= hang_en && (io_dout == hang_op);
            end
        end else if (io_valid && io_kind == 2'd2) begin
            rd_ptr <= rd_ptr + 8'd1;
        end else if (!io_rdy && !hanging) begin
            if (bcnt <= 1) io_rdy <= 1'b1;
            bcnt <= bcnt - 1;
        end
    end

    // ---------------- operation log ----------------
    logic [1:0] log_k [128];
    logic [7:0] log_b [128];
    int         log_n;
    always @(posedge clk) begin
        if (!rst_n) log_n <= 0;
        else if (io_valid && log_n < 128) begin
            log_k[log_n] <= io_kind;
            log_b[log_n] <= io_dout;
            log_n <= log_n + 1;
        end
    end

    logic [1:0] exp_k [128];
    logic [7:0] exp_b [128];
    int         exp_n;

    task automatic ex(input logic [1:0] k, input logic [7:0] b, input int rep);
        for (int i = 0; i < rep; i++) begin
            exp_k[exp_n] = k; exp_b[exp_n] = b; exp_n++;
        end
    endtask

    // ---------------- checking ----------------
    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_log(input string req);
        int first_bad = -1;
        check(req, "operation count", log_n, exp_n);
        for (int i = 0; i < exp_n && i < log_n; i++)
            if (first_bad < 0 && (log_k[i] != exp_k[i] ||
                (exp_k[i] != 2'd2 && log_b[i] != exp_b[i]))) first_bad = i;
        if (first_bad >= 0)
            check(req, "operation sequence at entry", {log_k[first_bad], log_b[first_bad]},
                  {exp_k[first_bad], exp_b[first_bad]});
        else
            check(req, "operation sequence", 0, 0);
    endtask

    task automatic boot(input logic sk, input logic sm, input logic np,
                        input logic onfi, input logic hen, input logic [7:0] hop);
        @(negedge clk);
        rst_n = 1'b0; s_skip = sk; s_small = sm; s_nopl = np;
        dev_onfi = onfi; hang_en = hen; hang_op = hop; exp_n = 0;
        repeat (3) @(negedge clk);
        check("R11", "rst_done in reset", rst_done, 0);
        check("R11", "busy in reset", busy, 1);
        check("R11", "io_valid/err/onfi in reset", {io_valid, err_timeout, onfi_found}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", "busy after release", busy, 1);
        for (int i = 0; i < 3000 && !rst_done; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        check("R9", "rst_done held and busy low", {rst_done, busy}, 2'b10);
    endtask

    task automatic seq_onfi();
        ex(2'd0, 8'hEC, 1); ex(2'd1, 8'h00, 1); ex(2'd2, 8'h00, 82);
    endtask
    task automatic seq_load();
        ex(2'd0, 8'h00, 1); ex(2'd1, 8'h00, 5); ex(2'd0, 8'h30, 1);
    endtask

    task automatic t_onfi();
        boot(0, 0, 0, 1, 0, 0);
        seq_onfi(); ex(2'd0, 8'hFF, 1); seq_load();
        check_log("R8");
        check("R3", "onfi_found", onfi_found, 1);
        check("R4", "par_mfr", par_mfr, 8'h2C);
        check("R4", "par_dev", par_dev, 0);
        check("R4", "par_page", par_page, 8192);
        check("R10", "err_timeout clear", err_timeout, 0);
    endtask

    task automatic t_legacy();
        boot(0, 0, 1, 0, 0, 0);
        ex(2'd0, 8'hEC, 1); ex(2'd1, 8'h00, 1); ex(2'd2, 8'h00, 4);
        ex(2'd0, 8'h90, 1); ex(2'd1, 8'h00, 1); ex(2'd2, 8'h00, 4);
        ex(2'd0, 8'hFF, 1);
        check_log("R5");
        check("R5", "onfi_found", onfi_found, 0);
        check("R5", "par_mfr", par_mfr, 8'hAD);
        check("R5", "par_dev", par_dev, 8'hDC);
        check("R5", "par_page", par_page, 4096);
    endtask

    task automatic t_skip();
        boot(1, 0, 0, 1, 0, 0);
        ex(2'd0, 8'hFF, 1); seq_load();
        check_log("R2");
        check("R2", "onfi_found", onfi_found, 0);
        check("R2", "par_page default", par_page, 2048);
    endtask

    task automatic t_small();
        boot(1, 1, 1, 1, 0, 0);
        ex(2'd0, 8'hFF, 1);
        check_log("R7");
        check("R6", "par_page small skip", par_page, 512);
        boot(0, 1, 1, 1, 0, 0);
        check("R6", "par_page small onfi", par_page, 512);
    endtask

    task automatic t_strap_late();
        @(negedge clk);
        rst_n = 1'b0; s_skip = 0; s_small = 0; s_nopl = 0;
        dev_onfi = 1; hang_en = 0; exp_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        s_skip = 1; s_small = 1; s_nopl = 1;
        for (int i = 0; i < 3000 && !rst_done; i++) @(negedge clk);
        seq_onfi(); ex(2'd0, 8'hFF, 1); seq_load();
        check_log("R1");
        check("R1", "par_page not forced", par_page, 8192);
    endtask

    task automatic t_timeout();
        boot(0, 0, 0, 1, 1, 8'hEC);
        ex(2'd0, 8'hEC, 1); ex(2'd1, 8'h00, 1);
        check_log("R10");
        check("R10", "err_timeout on param wait", err_timeout, 1);
        boot(1, 0, 0, 1, 1, 8'hFF);
        exp_n = 0; ex(2'd0, 8'hFF, 1);
        check_log("R10");
        check("R10", "err_timeout on reset wait", err_timeout, 1);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_onfi();
        t_legacy();
        t_skip();
        t_small();
        t_strap_late();
        t_timeout();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule